// File: doc/BRIEF.md
# Per-Device Enable Controller with Settled Status

This block switches up to 32 on-chip devices on and off. Each device has a small numeric ID. Its control field sits inside one of a few control registers. A parameter table splits the ID space into ranges. Each range gives its first ID, its ID count, the register it lives in, its lowest bit, its field width, and the codes that mean "on" and "off". The field of one device therefore starts at the range's lowest bit plus the field width times the device's offset inside the range.

A host issues a request with an ID and a direction (on or off). The block looks the ID up, checks the request, and updates only the target field by read-modify-write. It drives one enable line per device. A status register uses the same field positions, but with its own codes per range. It follows the control change after a fixed settling delay. The block pulses `done` when that status field reaches the expected code. While a change is settling, any new request is refused and `busy` stays high.

Top module: `devctl_top`

## Requirements
- R1: After reset, all control and status registers are zero, `busy`, `done`, `req_acc` and `req_rej` are low, and every `dev_en` line is low.
- R2: An accepted "on" request writes the range's enable code into the field that starts at bit `first_bit + width*(id - first_id)` of the range's control register. The default table has four ranges:
  - IDs 0..7 in register 0 from bit 0, 1-bit fields, on=1, off=0, status on=1, status off=0.
  - IDs 8..11 in register 0 from bit 8, 2-bit fields, on=2, off=1, status on=3, status off=0.
  - IDs 12..15 in register 1 from bit 0, 1-bit fields, on=1, off code 8'hFF, status on=1, status off=0.
  - IDs 16..19 in register 1 from bit 8, 3-bit fields, on=5, off=2, status on=7, status off=0.
  - Register k occupies bits k*32 and up of the flattened register ports.
- R3: An accepted "off" request writes the range's disable code into that same field.
- R4: A write changes only the target field; every other bit of every control register keeps its value.
- R5: A range whose disable code is 8'hFF is enable-only. An "off" request for one of its IDs is rejected, and the control and status registers are left unchanged.
- R6: A request whose ID is 32 or above, or whose ID falls in no range (IDs 20..31 by default), is rejected and changes no register.
- R7: The request is accepted at clock edge E. The target status field takes the range's status code for the requested direction at edge E+SETTLE_CYC and at no other edge. `done` is high for the one cycle after that edge, with `done_id` equal to the request's ID, and `busy` is low in that cycle.
- R8: `busy` is high from the edge after acceptance until the status update. A request presented while `busy` is high is rejected and changes no register.
- R9: `dev_en[i]` is high exactly when device i is mapped and its control field equals its range's enable code.
- R10: For each request sampled at an edge, exactly one of `req_acc` or `req_rej` is high for the following cycle. Both are low in cycles with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_id | input | ID_W (6) | Target device ID |
| req_enable | input | 1 | 1 = switch on, 0 = switch off |
| req_acc | output | 1 | Previous-cycle request was accepted |
| req_rej | output | 1 | Previous-cycle request was refused |
| busy | output | 1 | A state change is still settling |
| done | output | 1 | One-cycle pulse when status has settled |
| done_id | output | ID_W (6) | ID whose status just settled |
| dev_en | output | NUM_IDS (32) | Per-device enable lines |
| ctrl_regs | output | NUM_REGS*REG_W (64) | Control registers, register 0 at the low end |
| stat_regs | output | NUM_REGS*REG_W (64) | Status registers, same layout |

## Verification
The bench uses the default range table, so one register holds 1-bit and 2-bit fields side by side and the other holds an enable-only range next to 3-bit fields. It sets SETTLE_CYC to 3. With that value a second request can land in the middle of the settling window. The count of edges before `done` is small enough to check exactly. IDs 20..31 stay unmapped, and the 6-bit ID port lets the bench present IDs of 32 and above.

// File: rtl/devctl_pkg.sv
package devctl_pkg;

  localparam int MAP_W = 8;

  typedef struct packed {
    logic             hit;
    logic             enable_only;
    logic [MAP_W-1:0] reg_idx;
    logic [MAP_W-1:0] lsb;
    logic [MAP_W-1:0] nbits;
    logic [MAP_W-1:0] ctl_code;
    logic [MAP_W-1:0] st_code;
  } devctl_map_t;

  // lowest bit of a device field inside its register
  function automatic logic [MAP_W-1:0] field_lsb(input logic [MAP_W-1:0] first_bit,
                                                 input logic [MAP_W-1:0] width,
                                                 input logic [MAP_W-1:0] id,
                                                 input logic [MAP_W-1:0] first_id);
    logic [MAP_W-1:0] ofs;
    ofs = id - first_id;
    return first_bit + width * ofs;
  endfunction

  // mask of a field, up to 64 register bits
  function automatic logic [63:0] field_mask(input logic [MAP_W-1:0] lsb,
                                             input logic [MAP_W-1:0] width);
    logic [63:0] m;
    m = (64'd1 << width) - 64'd1;
    return m << lsb;
  endfunction

endpackage

// File: rtl/devctl_lookup.sv
module devctl_lookup
  import devctl_pkg::*;
#(
  parameter int NUM_IDS    = 32,
  parameter int ID_W       = 6,
  parameter int NUM_RANGES = 4,
  parameter logic [NUM_RANGES*8-1:0] RNG_START = '0,
  parameter logic [NUM_RANGES*8-1:0] RNG_COUNT = '0,
  parameter logic [NUM_RANGES*8-1:0] RNG_REG   = '0,
  parameter logic [NUM_RANGES*8-1:0] RNG_EN    = '0,
  parameter logic [NUM_RANGES*8-1:0] RNG_DIS   = '0,
  parameter logic [NUM_RANGES*8-1:0] RNG_SBIT  = '0,
  parameter logic [NUM_RANGES*8-1:0] RNG_NBITS = '0,
  parameter logic [NUM_RANGES*8-1:0] RNG_SEN   = '0,
  parameter logic [NUM_RANGES*8-1:0] RNG_SDIS  = '0
) (
  input  logic [ID_W-1:0] id,
  input  logic            want_en,
  output devctl_map_t     map
);

  logic [MAP_W-1:0] id8;
  logic [MAP_W:0]   lo_v, hi_v;

  assign id8 = MAP_W'(id);

  // walk from the top so that the lowest matching range wins
  always_comb begin
    map  = '0;
    lo_v = '0;
    hi_v = '0;
    for (int r = NUM_RANGES - 1; r >= 0; r--) begin
      lo_v = {1'b0, RNG_START[r*8 +: 8]};
      hi_v = {1'b0, RNG_START[r*8 +: 8]} + {1'b0, RNG_COUNT[r*8 +: 8]};
      if ({1'b0, id8} >= lo_v && {1'b0, id8} < hi_v) begin
        map.hit         = 1'b1;
        map.enable_only = (RNG_DIS[r*8 +: 8] == 8'hFF);
        map.reg_idx     = RNG_REG[r*8 +: 8];
        map.nbits       = RNG_NBITS[r*8 +: 8];
        map.lsb         = field_lsb(RNG_SBIT[r*8 +: 8], RNG_NBITS[r*8 +: 8],
                                    id8, RNG_START[r*8 +: 8]);
        map.ctl_code    = want_en ? RNG_EN[r*8 +: 8]  : RNG_DIS[r*8 +: 8];
        map.st_code     = want_en ? RNG_SEN[r*8 +: 8] : RNG_SDIS[r*8 +: 8];
      end
    end
    if (int'(id) >= NUM_IDS) map = '0;
  end

endmodule

// File: rtl/devctl_ctrl_regs.sv
module devctl_ctrl_regs #(
  parameter int NUM_REGS = 2,
  parameter int REG_W    = 32,
  parameter int RIDX_W   = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [RIDX_W-1:0]         wr_reg,
  input  logic [REG_W-1:0]          wr_mask,
  input  logic [REG_W-1:0]          wr_bits,
  output logic [NUM_REGS*REG_W-1:0] ctrl_flat
);

  logic [NUM_REGS*REG_W-1:0] chk_mask_flat;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [REG_W-1:0] q;
    logic             hit_reg;

    assign hit_reg = wr_en && (wr_reg == RIDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (hit_reg) q <= (q & ~wr_mask) | (wr_bits & wr_mask);
    end

    assign ctrl_flat[g*REG_W +: REG_W]     = q;
    assign chk_mask_flat[g*REG_W +: REG_W] = hit_reg ? wr_mask : '0;
  end

  // only the addressed field may move on a write (R4)
  p_rmw_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((ctrl_flat ^ $past(ctrl_flat)) & ~$past(chk_mask_flat)) == '0);

  // nothing moves without a write (R6)
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_flat));

endmodule

// File: rtl/devctl_settle.sv
module devctl_settle #(
  parameter int NUM_REGS   = 2,
  parameter int REG_W      = 32,
  parameter int RIDX_W     = 1,
  parameter int ID_W       = 6,
  parameter int SETTLE_CYC = 4,
  localparam int CNT_W     = $clog2(SETTLE_CYC + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [RIDX_W-1:0]         start_reg,
  input  logic [REG_W-1:0]          start_mask,
  input  logic [REG_W-1:0]          start_bits,
  input  logic [ID_W-1:0]           start_id,
  output logic                      busy,
  output logic                      done,
  output logic [ID_W-1:0]           done_id,
  output logic [NUM_REGS*REG_W-1:0] stat_flat
);

  logic [RIDX_W-1:0] pend_reg;
  logic [REG_W-1:0]  pend_mask, pend_bits;
  logic [ID_W-1:0]   pend_id;
  logic [CNT_W-1:0]  cnt;
  logic              busy_q, done_q;
  logic              settle_fin;

  assign settle_fin = busy_q && (cnt == CNT_W'(SETTLE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      cnt       <= '0;
      pend_reg  <= '0;
      pend_mask <= '0;
      pend_bits <= '0;
      pend_id   <= '0;
      done_id   <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q    <= 1'b1;
        cnt       <= '0;
        pend_reg  <= start_reg;
        pend_mask <= start_mask;
        pend_bits <= start_bits;
        pend_id   <= start_id;
      end else if (settle_fin) begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        done_id <= pend_id;
      end else if (busy_q) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_stat
    logic [REG_W-1:0] s;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s <= '0;
      else if (settle_fin && pend_reg == RIDX_W'(g))
        s <= (s & ~pend_mask) | (pend_bits & pend_mask);
    end
    assign stat_flat[g*REG_W +: REG_W] = s;
  end

  assign busy = busy_q;
  assign done = done_q;

  // status changes only at the end of a settling window (R7)
  p_stat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !settle_fin |=> $stable(stat_flat));

  // a done pulse always closes a busy window (R7)
  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(busy_q) && !busy_q));

  // a new change never starts over a pending one (R8)
  p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);

endmodule

// File: rtl/devctl_top.sv
module devctl_top
  import devctl_pkg::*;
#(
  parameter int NUM_IDS    = 32,
  parameter int NUM_REGS   = 2,
  parameter int REG_W      = 32,
  parameter int NUM_RANGES = 4,
  parameter int SETTLE_CYC = 4,
  parameter logic [NUM_RANGES*8-1:0] RNG_START = {8'd16, 8'd12, 8'd8, 8'd0},
  parameter logic [NUM_RANGES*8-1:0] RNG_COUNT = {8'd4,  8'd4,  8'd4, 8'd8},
  parameter logic [NUM_RANGES*8-1:0] RNG_REG   = {8'd1,  8'd1,  8'd0, 8'd0},
  parameter logic [NUM_RANGES*8-1:0] RNG_EN    = {8'd5,  8'd1,  8'd2, 8'd1},
  parameter logic [NUM_RANGES*8-1:0] RNG_DIS   = {8'd2,  8'hFF, 8'd1, 8'd0},
  parameter logic [NUM_RANGES*8-1:0] RNG_SBIT  = {8'd8,  8'd0,  8'd8, 8'd0},
  parameter logic [NUM_RANGES*8-1:0] RNG_NBITS = {8'd3,  8'd1,  8'd2, 8'd1},
  parameter logic [NUM_RANGES*8-1:0] RNG_SEN   = {8'd7,  8'd1,  8'd3, 8'd1},
  parameter logic [NUM_RANGES*8-1:0] RNG_SDIS  = {8'd0,  8'd0,  8'd0, 8'd0},
  localparam int ID_W   = $clog2(NUM_IDS) + 1,
  localparam int RIDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [ID_W-1:0]           req_id,
  input  logic                      req_enable,
  output logic                      req_acc,
  output logic                      req_rej,
  output logic                      busy,
  output logic                      done,
  output logic [ID_W-1:0]           done_id,
  output logic [NUM_IDS-1:0]        dev_en,
  output logic [NUM_REGS*REG_W-1:0] ctrl_regs,
  output logic [NUM_REGS*REG_W-1:0] stat_regs
);

  devctl_map_t      req_map;
  logic [63:0]      mask_wide;
  logic [REG_W-1:0] wr_mask, wr_ctl_bits, wr_st_bits;
  logic             accept;
  logic             req_acc_q, req_rej_q;

  devctl_lookup #(
    .NUM_IDS(NUM_IDS), .ID_W(ID_W), .NUM_RANGES(NUM_RANGES),
    .RNG_START(RNG_START), .RNG_COUNT(RNG_COUNT), .RNG_REG(RNG_REG),
    .RNG_EN(RNG_EN), .RNG_DIS(RNG_DIS), .RNG_SBIT(RNG_SBIT),
    .RNG_NBITS(RNG_NBITS), .RNG_SEN(RNG_SEN), .RNG_SDIS(RNG_SDIS)
  ) u_req_map (
    .id(req_id), .want_en(req_enable), .map(req_map)
  );

  assign mask_wide   = field_mask(req_map.lsb, req_map.nbits);
  assign wr_mask     = mask_wide[REG_W-1:0];
  assign wr_ctl_bits = (REG_W'(req_map.ctl_code) << req_map.lsb) & wr_mask;
  assign wr_st_bits  = (REG_W'(req_map.st_code)  << req_map.lsb) & wr_mask;

  assign accept = req_valid && !busy && req_map.hit &&
                  (req_enable || !req_map.enable_only);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_acc_q <= 1'b0;
      req_rej_q <= 1'b0;
    end else begin
      req_acc_q <= accept;
      req_rej_q <= req_valid && !accept;
    end
  end

  assign req_acc = req_acc_q;
  assign req_rej = req_rej_q;

  devctl_ctrl_regs #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .RIDX_W(RIDX_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(accept), .wr_reg(req_map.reg_idx[RIDX_W-1:0]),
    .wr_mask(wr_mask), .wr_bits(wr_ctl_bits),
    .ctrl_flat(ctrl_regs)
  );

  devctl_settle #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .RIDX_W(RIDX_W),
    .ID_W(ID_W), .SETTLE_CYC(SETTLE_CYC)
  ) u_settle (
    .clk(clk), .rst_n(rst_n),
    .start(accept), .start_reg(req_map.reg_idx[RIDX_W-1:0]),
    .start_mask(wr_mask), .start_bits(wr_st_bits), .start_id(req_id),
    .busy(busy), .done(done), .done_id(done_id),
    .stat_flat(stat_regs)
  );

  // one lookup per device decodes its enable line from the control registers
  for (genvar d = 0; d < NUM_IDS; d++) begin : g_dev
    devctl_map_t      dmap;
    logic [NUM_REGS*REG_W-1:0] shifted;
    logic [63:0]      fm_wide;
    logic [7:0]       fmask;
    logic             en_bit;

    devctl_lookup #(
      .NUM_IDS(NUM_IDS), .ID_W(ID_W), .NUM_RANGES(NUM_RANGES),
      .RNG_START(RNG_START), .RNG_COUNT(RNG_COUNT), .RNG_REG(RNG_REG),
      .RNG_EN(RNG_EN), .RNG_DIS(RNG_DIS), .RNG_SBIT(RNG_SBIT),
      .RNG_NBITS(RNG_NBITS), .RNG_SEN(RNG_SEN), .RNG_SDIS(RNG_SDIS)
    ) u_dev_map (
      .id(ID_W'(d)), .want_en(1'b1), .map(dmap)
    );

    always_comb begin
      shifted = ctrl_regs >> (int'(dmap.reg_idx) * REG_W + int'(dmap.lsb));
      fm_wide = field_mask(8'd0, dmap.nbits);
      fmask   = fm_wide[7:0];
      en_bit  = dmap.hit && ((shifted[7:0] & fmask) == (dmap.ctl_code & fmask));
    end

    assign dev_en[d] = en_bit;
  end

  // a request during a pending change is refused (R8)
  p_busy_refuse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> (req_rej && !req_acc));

  // disable of an enable-only device is refused (R5)
  p_enonly_refuse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_enable && req_map.hit && req_map.enable_only) |=> req_rej);

  // out-of-table IDs are refused (R6)
  p_unmapped_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_map.hit) |=> (req_rej && !req_acc));

  // response pulses never overlap and follow a request (R10)
  p_resp_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_acc, req_rej}));
  p_resp_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!req_acc && !req_rej));

  // done is only seen with busy released (R7)
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/devctl_top_test.sv
`timescale 1ns/1ps
module devctl_top_test;

  localparam int SETTLE = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [5:0]  req_id = '0;
  logic        req_enable = 1'b0;
  logic        req_acc, req_rej, busy, done;
  logic [5:0]  done_id;
  logic [31:0] dev_en;
  logic [63:0] ctrl_regs, stat_regs;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m_ctrl [2];
  logic [31:0] m_stat [2];

  // bench restatement of the default table
  int b_first [4] = '{0, 8, 12, 16};
  int b_reg   [4] = '{0, 0, 1, 1};
  int b_bit   [4] = '{0, 8, 0, 8};
  int b_wid   [4] = '{1, 2, 1, 3};
  int b_on    [4] = '{1, 2, 1, 5};
  int b_off   [4] = '{0, 1, 255, 2};
  int b_son   [4] = '{1, 3, 1, 7};
  int b_soff  [4] = '{0, 0, 0, 0};

  devctl_top #(.SETTLE_CYC(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .req_enable(req_enable), .req_acc(req_acc), .req_rej(req_rej),
    .busy(busy), .done(done), .done_id(done_id), .dev_en(dev_en),
    .ctrl_regs(ctrl_regs), .stat_regs(stat_regs)
  );

  always #10 clk = ~clk;

  function automatic int rng_of(int id);
    if (id < 8)  return 0;
    if (id < 12) return 1;
    if (id < 16) return 2;
    if (id < 20) return 3;
    return -1;
  endfunction

  function automatic logic [63:0] m_ctrl_flat();
    return {m_ctrl[1], m_ctrl[0]};
  endfunction

  function automatic logic [63:0] m_stat_flat();
    return {m_stat[1], m_stat[0]};
  endfunction

  function automatic logic [31:0] exp_dev_en();
    logic [31:0] v = '0;
    for (int d = 0; d < 20; d++) begin
      int r = rng_of(d);
      int pos = b_bit[r] + b_wid[r] * (d - b_first[r]);
      int fld = int'((m_ctrl[b_reg[r]] >> pos) & ((32'd1 << b_wid[r]) - 1));
      v[d] = (fld == b_on[r]);
    end
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(ctrl_regs == '0, "R1", "ctrl after reset", ctrl_regs, 64'd0);
    chk(stat_regs == '0, "R1", "stat after reset", stat_regs, 64'd0);
    chk({busy, done, req_acc, req_rej} == 4'b0, "R1", "flags after reset",
        {60'd0, busy, done, req_acc, req_rej}, 64'd0);
    chk(dev_en == '0, "R1", "dev_en after reset", dev_en, 64'd0);
  endtask

  // issue one request; checks response, control, then settle timing and status
  task automatic do_req(input int id, input bit en, input bit exp_ok);
    logic [63:0] st_before;
    int r, pos;
    int k;
    st_before = stat_regs;
    @(negedge clk);
    req_valid = 1'b1; req_id = 6'(id); req_enable = en;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r = rng_of(id);
    if (exp_ok) begin
      pos = b_bit[r] + b_wid[r] * (id - b_first[r]);
      m_ctrl[b_reg[r]] = (m_ctrl[b_reg[r]] & ~(((32'd1 << b_wid[r]) - 1) << pos)) |
                         (32'(en ? b_on[r] : b_off[r]) << pos);
    end
    chk(req_acc == exp_ok && req_rej == !exp_ok, "R10", "accept/reject pulse",
        {62'd0, req_acc, req_rej}, {62'd0, exp_ok, !exp_ok});
    chk(ctrl_regs == m_ctrl_flat(), en ? "R2" : "R3", "control field after write (R4 keep)",
        ctrl_regs, m_ctrl_flat());
    chk(dev_en == exp_dev_en(), "R9", "dev_en lines", dev_en, exp_dev_en());
    if (!exp_ok) begin
      chk(stat_regs == st_before && !busy, "R6", "status untouched by refused request",
          stat_regs, st_before);
      return;
    end
    chk(busy == 1'b1, "R8", "busy after accept", busy, 1);
    k = 0;
    for (int i = 1; i <= SETTLE + 3; i++) begin
      if (done) break;
      chk(stat_regs == st_before, "R7", "status before settle", stat_regs, st_before);
      @(posedge clk);
      @(negedge clk);
      k = i;
    end
    m_stat[b_reg[r]] = (m_stat[b_reg[r]] & ~(((32'd1 << b_wid[r]) - 1) << pos)) |
                       (32'(en ? b_son[r] : b_soff[r]) << pos);
    chk(k == SETTLE, "R7", "edges from accept to done", k, SETTLE);
    chk(stat_regs == m_stat_flat(), "R7", "status after settle", stat_regs, m_stat_flat());
    chk(done_id == 6'(id) && !busy, "R7", "done_id and busy", {busy, done_id}, id);
    @(negedge clk);
    chk(!done, "R7", "done is one cycle", done, 0);
  endtask

  // a second request arrives while the first is settling
  task automatic t_busy_refuse();
    logic [63:0] c_before;
    @(negedge clk);
    req_valid = 1'b1; req_id = 6'd3; req_enable = 1'b1;
    @(posedge clk);
    @(negedge clk);
    m_ctrl[0][3] = 1'b1;
    c_before = m_ctrl_flat();
    chk(req_acc && busy, "R8", "first request accepted", {req_acc, busy}, 2'b11);
    req_id = 6'd4;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_rej && !req_acc, "R8", "request refused while busy",
        {req_acc, req_rej}, 2'b01);
    chk(ctrl_regs == c_before, "R8", "refused request leaves control", ctrl_regs, c_before);
    for (int i = 0; i < SETTLE + 3 && !done; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
    m_stat[0][3] = 1'b1;
    chk(done && done_id == 6'd3, "R7", "first request completes", done_id, 3);
    chk(stat_regs == m_stat_flat(), "R8", "only first request in status",
        stat_regs, m_stat_flat());
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_ctrl[0] = '0; m_ctrl[1] = '0;
    m_stat[0] = '0; m_stat[1] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    do_req(0, 1'b1, 1'b1);   // R2 1-bit field
    do_req(5, 1'b1, 1'b1);   // R2, R4 id 0 kept
    do_req(9, 1'b1, 1'b1);   // R2 2-bit field beside 1-bit ones
    do_req(0, 1'b0, 1'b1);   // R3
    do_req(9, 1'b0, 1'b1);   // R3 disable code 1
    do_req(13, 1'b1, 1'b1);  // R2 enable-only range
    do_req(13, 1'b0, 1'b0);  // R5 refused
    do_req(17, 1'b1, 1'b1);  // R2 3-bit field
    do_req(19, 1'b1, 1'b1);  // R4 top field of range
    do_req(17, 1'b0, 1'b0 == 1'b1 ? 1'b0 : 1'b1); // R3
    do_req(25, 1'b1, 1'b0);  // R6 unmapped
    do_req(40, 1'b1, 1'b0);  // R6 beyond 32
    do_req(32, 1'b0, 1'b0);  // R6 boundary
    t_busy_refuse();
    @(negedge clk);
    chk(dev_en == exp_dev_en(), "R9", "final dev_en", dev_en, exp_dev_en());
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule